// File: doc/BRIEF.md
# Sensor start-up and scan sequencer

This controller sits above a frame transceiver that carries one register command at a time to an inertial sensor and hands back a response. After reset it brings the sensor up by itself: a software reset, a settle delay, an identity read that tells the two supported variants apart, and, on the variant that has angle outputs, a write that turns those outputs on. Once this start-up is done it raises `init_done` and waits for scan triggers.

Each trigger starts one scan frame. A frame reads a fixed list of data registers in a fixed order. Each good result is presented as a 16-bit sample with a channel index, and a frame-complete strobe marks the last one. The list holds four channels on the first variant and seven on the second. When a response carries the error return status or a CRC failure, the sequencer issues one read of the status register. That read clears the sensor's error, and the low nine bits of its data are published. A frame that hits an error is dropped. An error during start-up is cleared the same way, and start-up then begins again from the reset write.

Top module: `sens_seq`

## Requirements
- R1: The first command after reset is a write (`cmd_write`=1) of data 0x0020 to register address 0x0D.
- R2: After the response to that reset write, no command is issued for at least SETTLE_CYC cycles. The next command follows within a few cycles of that window and is a read of address 0x10.
- R3: Identity data 0x0051 selects variant A (`variant_b`=0) and 0x00C1 selects variant B (`variant_b`=1). Any other value sets `fault_unknown`, after which no command is issued and `init_done` stays 0.
- R4: On variant B only, start-up ends with a write of 0x001F to address 0x0C. On variant A the identity read is the last start-up command. `init_done` rises after the last start-up command.
- R5: On variant A a frame reads addresses 0x01, 0x02, 0x03, 0x05 in that order. It presents each result on `smp_data` with `smp_chan` 0..3, and `frame_done` is high together with the channel 3 sample.
- R6: On variant B a frame continues after the 0x05 read with reads of 0x09, 0x0A, 0x0B as channels 4..6, and `frame_done` comes with channel 6.
- R7: `scan_trig` has no effect before `init_done` or while a frame is in progress; exactly one frame runs per accepted trigger.
- R8: A response with `rsp_status`=2'b11 is followed by a read of address 0x06. Bits 8:0 of that read's data appear on `stat_val` with a one-cycle `stat_valid`.
- R9: An error during a frame ends that frame: no further channel is read, no sample is produced for the failed channel, and `frame_done` is not raised. The next trigger starts again at channel 0.
- R10: A response with `rsp_crc_err`=1 is handled exactly as in R8 and R9.
- R11: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_write`, `cmd_addr` and `cmd_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_trig | input | 1 | Pulse that requests one scan frame |
| cmd_valid | output | 1 | Command offered to the transceiver |
| cmd_ready | input | 1 | Transceiver takes the command |
| cmd_write | output | 1 | 1 = register write, 0 = read |
| cmd_addr | output | ADDR_W | Register address |
| cmd_wdata | output | DATA_W | Write data |
| rsp_valid | input | 1 | Response strobe for the outstanding command |
| rsp_status | input | 2 | Return status; 2'b11 means error |
| rsp_crc_err | input | 1 | Response failed its CRC check |
| rsp_rdata | input | DATA_W | Response data |
| init_done | output | 1 | Start-up sequence complete |
| variant_b | output | 1 | Identity decoded as variant B |
| fault_unknown | output | 1 | Identity not recognised; sequencer halted |
| smp_valid | output | 1 | Sample strobe |
| smp_chan | output | CHAN_W | Channel index of the sample |
| smp_data | output | DATA_W | Sample value |
| frame_done | output | 1 | Last sample of a complete frame |
| stat_valid | output | 1 | Status value updated |
| stat_val | output | STAT_W | Latched device status bits |

## Verification
The bench builds the block with SETTLE_CYC set to 40 and keeps the default widths. The short settle window lets a single run reset the block three times, once for each identity outcome (variant A, variant B, unknown), and still measure the delay window cycle by cycle. The transceiver model stalls every command and answers late. This exercises the command hold rule and keeps responses well separated from new triggers, so the bench can inject errors at a chosen address, including the last channel of a frame.

// File: rtl/sseq_pkg.sv
package sseq_pkg;
  typedef enum logic [2:0] {
    ST_RST_WR, ST_SETTLE, ST_ID_RD, ST_ANG_WR,
    ST_IDLE, ST_SCAN, ST_STAT_RD, ST_HALT
  } sseq_st_e;

  localparam logic [4:0]  RG_MODE  = 5'h0D;
  localparam logic [4:0]  RG_ID    = 5'h10;
  localparam logic [4:0]  RG_ANG   = 5'h0C;
  localparam logic [4:0]  RG_STAT  = 5'h06;
  localparam logic [15:0] V_SWRST  = 16'h0020;
  localparam logic [15:0] V_ANG_ON = 16'h001F;
  localparam logic [15:0] ID_VAR_A = 16'h0051;
  localparam logic [15:0] ID_VAR_B = 16'h00C1;
  localparam logic [1:0]  RS_ERR   = 2'b11;
  localparam int          LAST_A   = 3;
  localparam int          LAST_B   = 6;
endpackage

// File: rtl/sseq_timer.sv
module sseq_timer #(
  parameter int CYC = 2_600_000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic expired
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (start)     cnt <= CW'(CYC);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R2: once loaded, the window runs down one step per cycle
  p_countdown_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0 && !start) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/sseq_chan_map.sv
module sseq_chan_map #(
  parameter int CHAN_W = 3,
  parameter int ADDR_W = 5
) (
  input  logic [CHAN_W-1:0] idx,
  output logic [ADDR_W-1:0] addr
);
  // channels 0..2 -> 1..3, channel 3 -> 5, channels 4..6 -> 9..11
  always_comb begin
    if (idx < CHAN_W'(3))       addr = ADDR_W'(idx) + ADDR_W'(1);
    else if (idx == CHAN_W'(3)) addr = ADDR_W'(5);
    else                        addr = ADDR_W'(idx) + ADDR_W'(5);
  end
endmodule

// File: rtl/sseq_id_dec.sv
module sseq_id_dec #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] id,
  output logic              known,
  output logic              is_b
);
  import sseq_pkg::*;
  logic hit_a;
  always_comb begin
    hit_a = (id == DATA_W'(ID_VAR_A));
    is_b  = (id == DATA_W'(ID_VAR_B));
    known = hit_a | is_b;
  end
endmodule

// File: rtl/sens_seq.sv
module sens_seq
  import sseq_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 16,
  parameter int STAT_W     = 9,
  parameter int CHAN_W     = 3,
  parameter int SETTLE_CYC = 2_600_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scan_trig,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_wdata,
  input  logic              rsp_valid,
  input  logic [1:0]        rsp_status,
  input  logic              rsp_crc_err,
  input  logic [DATA_W-1:0] rsp_rdata,
  output logic              init_done,
  output logic              variant_b,
  output logic              fault_unknown,
  output logic              smp_valid,
  output logic [CHAN_W-1:0] smp_chan,
  output logic [DATA_W-1:0] smp_data,
  output logic              frame_done,
  output logic              stat_valid,
  output logic [STAT_W-1:0] stat_val
);
  localparam logic [CHAN_W-1:0] LAST_CH_A = CHAN_W'(LAST_A);
  localparam logic [CHAN_W-1:0] LAST_CH_B = CHAN_W'(LAST_B);

  sseq_st_e          st;
  logic [CHAN_W-1:0] idx, idx_sel;
  logic [ADDR_W-1:0] ch_addr;
  logic              tmr_start, tmr_exp, id_known, id_b, ret_scan;
  logic              rsp_take, rsp_bad, at_last;

  sseq_timer #(.CYC(SETTLE_CYC)) u_timer (
    .clk(clk), .rst(rst), .start(tmr_start), .expired(tmr_exp));

  sseq_chan_map #(.CHAN_W(CHAN_W), .ADDR_W(ADDR_W)) u_map (
    .idx(idx_sel), .addr(ch_addr));

  sseq_id_dec #(.DATA_W(DATA_W)) u_id (
    .id(rsp_rdata), .known(id_known), .is_b(id_b));

  always_comb begin
    idx_sel  = (st == ST_SCAN) ? idx + 1'b1 : '0;
    rsp_take = rsp_valid && !cmd_valid;
    rsp_bad  = rsp_crc_err || (rsp_status == RS_ERR);
    at_last  = (idx == (variant_b ? LAST_CH_B : LAST_CH_A));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_RST_WR;
      cmd_valid     <= 1'b1;
      cmd_write     <= 1'b1;
      cmd_addr      <= ADDR_W'(RG_MODE);
      cmd_wdata     <= DATA_W'(V_SWRST);
      idx           <= '0;
      tmr_start     <= 1'b0;
      ret_scan      <= 1'b0;
      init_done     <= 1'b0;
      variant_b     <= 1'b0;
      fault_unknown <= 1'b0;
      smp_valid     <= 1'b0;
      smp_chan      <= '0;
      smp_data      <= '0;
      frame_done    <= 1'b0;
      stat_valid    <= 1'b0;
      stat_val      <= '0;
    end else begin
      smp_valid  <= 1'b0;
      frame_done <= 1'b0;
      stat_valid <= 1'b0;
      tmr_start  <= 1'b0;
      if (cmd_valid && cmd_ready) cmd_valid <= 1'b0;

      if (rsp_take && rsp_bad && st != ST_STAT_RD &&
          (st == ST_RST_WR || st == ST_ID_RD || st == ST_ANG_WR || st == ST_SCAN)) begin
        ret_scan  <= (st == ST_SCAN);
        st        <= ST_STAT_RD;
        cmd_valid <= 1'b1;
        cmd_write <= 1'b0;
        cmd_addr  <= ADDR_W'(RG_STAT);
        cmd_wdata <= '0;
      end else begin
        case (st)
          ST_RST_WR: if (rsp_take) begin
            st        <= ST_SETTLE;
            tmr_start <= 1'b1;
          end
          ST_SETTLE: if (tmr_exp && !tmr_start) begin
            st        <= ST_ID_RD;
            cmd_valid <= 1'b1;
            cmd_write <= 1'b0;
            cmd_addr  <= ADDR_W'(RG_ID);
            cmd_wdata <= '0;
          end
          ST_ID_RD: if (rsp_take) begin
            if (!id_known) begin
              fault_unknown <= 1'b1;
              st            <= ST_HALT;
            end else if (id_b) begin
              variant_b <= 1'b1;
              st        <= ST_ANG_WR;
              cmd_valid <= 1'b1;
              cmd_write <= 1'b1;
              cmd_addr  <= ADDR_W'(RG_ANG);
              cmd_wdata <= DATA_W'(V_ANG_ON);
            end else begin
              variant_b <= 1'b0;
              init_done <= 1'b1;
              st        <= ST_IDLE;
            end
          end
          ST_ANG_WR: if (rsp_take) begin
            init_done <= 1'b1;
            st        <= ST_IDLE;
          end
          ST_IDLE: if (scan_trig) begin
            idx       <= '0;
            st        <= ST_SCAN;
            cmd_valid <= 1'b1;
            cmd_write <= 1'b0;
            cmd_addr  <= ch_addr;
            cmd_wdata <= '0;
          end
          ST_SCAN: if (rsp_take) begin
            smp_valid <= 1'b1;
            smp_chan  <= idx;
            smp_data  <= rsp_rdata;
            if (at_last) begin
              frame_done <= 1'b1;
              st         <= ST_IDLE;
            end else begin
              idx       <= idx + 1'b1;
              cmd_valid <= 1'b1;
              cmd_addr  <= ch_addr;
            end
          end
          ST_STAT_RD: if (rsp_take) begin
            stat_val   <= rsp_rdata[STAT_W-1:0];
            stat_valid <= 1'b1;
            if (ret_scan) st <= ST_IDLE;
            else begin
              st        <= ST_RST_WR;
              cmd_valid <= 1'b1;
              cmd_write <= 1'b1;
              cmd_addr  <= ADDR_W'(RG_MODE);
              cmd_wdata <= DATA_W'(V_SWRST);
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_cmd_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) &&
                                   $stable(cmd_wdata) && $stable(cmd_write)));
  p_halt_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    fault_unknown |=> (fault_unknown && !cmd_valid && !init_done));
  p_done_last_r5: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (smp_valid && smp_chan == (variant_b ? LAST_CH_B : LAST_CH_A)));
  p_smp_after_init_r7: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> init_done);
  p_excl_out_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({smp_valid, stat_valid}));
endmodule

// File: tb/sens_seq_tb.sv
module sens_seq_tb;
  localparam int S = 40;
  logic clk = 1'b0, rst = 1'b1, scan_trig = 1'b0;
  logic cmd_valid, cmd_ready, cmd_write;
  logic [4:0] cmd_addr;
  logic [15:0] cmd_wdata, rsp_rdata, smp_data;
  logic rsp_valid, rsp_crc_err;
  logic [1:0] rsp_status;
  logic init_done, variant_b, fault_unknown, smp_valid, frame_done, stat_valid;
  logic [2:0] smp_chan;
  logic [8:0] stat_val;

  sens_seq #(.SETTLE_CYC(S)) u_dut (
    .clk(clk), .rst(rst), .scan_trig(scan_trig),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
    .rsp_status(rsp_status), .rsp_crc_err(rsp_crc_err), .rsp_rdata(rsp_rdata),
    .init_done(init_done), .variant_b(variant_b), .fault_unknown(fault_unknown),
    .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_data(smp_data),
    .frame_done(frame_done), .stat_valid(stat_valid), .stat_val(stat_val));

  always #2 clk = ~clk;

  int n_run = 0, n_fail = 0, cyc = 0;
  int nframes = 0, nstat = 0, t_rst_rsp = 0, t_id = 0, err_addr = -1;
  bit err_crc = 0;
  logic [15:0] id_val = 16'h0051;
  logic [7:0]  dbase = 8'h30;
  logic [8:0]  last_stat = '0;
  logic [21:0] log_q[$];
  logic [18:0] exp_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] tb_addr(int c);
    case (c)
      0: return 5'h01; 1: return 5'h02; 2: return 5'h03; 3: return 5'h05;
      4: return 5'h09; 5: return 5'h0A; default: return 5'h0B;
    endcase
  endfunction

  // transceiver model: stalls each command, answers a few cycles later
  initial begin
    logic [21:0] ent;
    cmd_ready = 0; rsp_valid = 0; rsp_status = 0; rsp_crc_err = 0; rsp_rdata = 0;
    forever begin
      @(negedge clk);
      if (cmd_valid && !rst) begin
        ent = {cmd_write, cmd_addr, cmd_wdata};
        if (cmd_addr == 5'h10) t_id = cyc;
        repeat (2) @(negedge clk);
        chk("R11 hold", {10'b0, cmd_valid, cmd_write, cmd_addr, cmd_wdata}, {10'b0, 1'b1, ent});
        cmd_ready = 1;
        @(negedge clk);
        cmd_ready = 0;
        log_q.push_back(ent);
        repeat (2) @(negedge clk);
        if (!rst) begin
          rsp_valid = 1; rsp_status = 2'b00; rsp_crc_err = 0; rsp_rdata = '0;
          if (ent[21] && ent[20:16] == 5'h0D) t_rst_rsp = cyc;
          if (!ent[21]) begin
            if (ent[20:16] == 5'h10) rsp_rdata = id_val;
            else if (ent[20:16] == 5'h06) begin rsp_rdata = 16'hA5C3; rsp_status = 2'b11; end
            else rsp_rdata = {dbase, 3'b0, ent[20:16]};
            if (int'(ent[20:16]) == err_addr) begin
              if (err_crc) rsp_crc_err = 1; else rsp_status = 2'b11;
              err_addr = -1;
            end
          end
          @(negedge clk);
          rsp_valid = 0; rsp_status = 0; rsp_crc_err = 0;
        end
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (smp_valid) begin
        if (exp_q.size() == 0) chk("R5 unexpected sample", {13'b0, smp_chan, smp_data}, 32'hFFFF_FFFF);
        else chk("R5/R6 sample", {13'b0, smp_chan, smp_data}, {13'b0, exp_q.pop_front()});
      end
      if (frame_done) nframes++;
      if (stat_valid) begin nstat++; last_stat = stat_val; end
    end
  end

  task automatic do_reset(logic [15:0] id);
    id_val = id; rst = 1; log_q.delete(); exp_q.delete(); nframes = 0; nstat = 0;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic wait_init();
    int k = 0;
    while (!init_done && k < S + 200) begin @(negedge clk); k++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_trig();
    scan_trig = 1; @(negedge clk); scan_trig = 0;
  endtask

  task automatic push_exp(int n);
    for (int c = 0; c < n; c++) exp_q.push_back({3'(c), dbase, 3'b0, tb_addr(c)});
  endtask

  task automatic run_frame(int n);
    int f0 = nframes, k = 0;
    push_exp(n);
    pulse_trig();
    while (nframes == f0 && k < 300) begin @(negedge clk); k++; end
    repeat (10) @(negedge clk);
  endtask

  task automatic check_reads(string req, int first, int n);
    for (int c = 0; c < n; c++)
      chk(req, {10'b0, log_q[first + c]}, {10'b0, 1'b0, tb_addr(c), 16'h0});
  endtask

  initial begin
    int base, f0, s0;
    @(negedge clk);
    chk("reset smp_valid", {31'b0, smp_valid}, 0);
    chk("reset init_done", {31'b0, init_done}, 0);
    chk("R1 reset cmd_valid", {31'b0, cmd_valid}, 1);
    do_reset(16'h0051);
    repeat (20) @(negedge clk);
    pulse_trig();                                   // R7: ignored before init
    wait_init();
    chk("R1 first cmd", {10'b0, log_q[0]}, {10'b0, 1'b1, 5'h0D, 16'h0020});
    chk("R2 settle low bound", {31'b0, (t_id - t_rst_rsp) >= S + 1}, 1);
    chk("R2 settle high bound", {31'b0, (t_id - t_rst_rsp) <= S + 6}, 1);
    chk("R2 id read", {10'b0, log_q[1]}, {10'b0, 1'b0, 5'h10, 16'h0});
    chk("R4 no angle write on A", log_q.size(), 2);
    chk("R3 variant A", {31'b0, variant_b}, 0);
    chk("R7 no frame before init", nframes, 0);

    run_frame(4);                                   // R5
    chk("R5 frame count", nframes, 1);
    chk("R5 queue drained", exp_q.size(), 0);
    check_reads("R5 read order", 2, 4);

    dbase = 8'h41; f0 = nframes; base = log_q.size();
    push_exp(4);
    pulse_trig(); repeat (4) @(negedge clk); pulse_trig();   // R7: second trigger mid-frame
    repeat (150) @(negedge clk);
    chk("R7 one frame per trigger", nframes, f0 + 1);
    chk("R7 reads count", log_q.size(), base + 4);

    dbase = 8'h52; f0 = nframes; s0 = nstat; base = log_q.size();
    push_exp(1); err_addr = 2; err_crc = 0;          // R8 R9
    pulse_trig(); repeat (150) @(negedge clk);
    chk("R8 status strobe", nstat, s0 + 1);
    chk("R8 status value", {23'b0, last_stat}, {23'b0, 9'h1C3});
    chk("R8 status read", {10'b0, log_q[base + 2]}, {10'b0, 1'b0, 5'h06, 16'h0});
    chk("R9 frame dropped", nframes, f0);
    chk("R9 no further reads", log_q.size(), base + 3);
    chk("R9 no sample for failed channel", exp_q.size(), 0);
    run_frame(4);
    chk("R9 restart at channel 0", nframes, f0 + 1);
    check_reads("R9 restart order", base + 3, 4);

    dbase = 8'h63; f0 = nframes; s0 = nstat;
    push_exp(3); err_addr = 5; err_crc = 1;          // R10
    pulse_trig(); repeat (150) @(negedge clk);
    chk("R10 crc status strobe", nstat, s0 + 1);
    chk("R10 crc frame dropped", nframes, f0);
    chk("R10 crc last cmd", {10'b0, log_q[log_q.size() - 1]}, {10'b0, 1'b0, 5'h06, 16'h0});
    chk("R10 queue drained", exp_q.size(), 0);

    do_reset(16'h00C1);                             // variant B
    wait_init();
    chk("R3 variant B", {31'b0, variant_b}, 1);
    chk("R4 angle write", {10'b0, log_q[2]}, {10'b0, 1'b1, 5'h0C, 16'h001F});
    chk("R4 init_done B", {31'b0, init_done}, 1);
    dbase = 8'h74;
    run_frame(7);
    chk("R6 frame count", nframes, 1);
    chk("R6 queue drained", exp_q.size(), 0);
    check_reads("R6 read order", 3, 7);

    do_reset(16'h0033);                             // unknown identity
    repeat (S + 80) @(negedge clk);
    pulse_trig(); repeat (40) @(negedge clk);
    chk("R3 fault set", {31'b0, fault_unknown}, 1);
    chk("R3 init_done low", {31'b0, init_done}, 0);
    chk("R3 halted", log_q.size(), 2);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule